// File: doc/BRIEF.md
# Direction-Aware GPIO Port Data Register

This block holds the data word of a twelve-pin general-purpose I/O port. It sits on a simple synchronous register bus that carries an address, separate read and write strobes, write data and combinational read data. Two per-pin vectors arrive from elsewhere: a direction vector (1 = output) and a function-select vector (1 = the pin is used as plain I/O rather than by a peripheral). The block drives a data value and an output enable toward each pad. It also takes in the raw pad levels through its own synchronizer.

A read returns a per-pin mixture. Pins set as inputs report their synchronized pad level. Pins set as outputs report the latched bit. The four upper bits of the word are fixed at one. A write always lands in the latch. The value only reaches a pad when that pin is both an output and in plain-I/O use. The reset sources are handled differently. A full power-on reset and hardware standby clear the latch. A watchdog-caused power-on reset, software standby and sleep keep the latch intact.

Top module: `gpio_data_port`

## Requirements
- R1: Read bits 15..12 always return 1. The write data in bits 15..12 is discarded and never changes any read bit or pad output.
- R2: While `por_n` is low, bits 11..0 of the latch are 0. After release, a read with every pin set as output returns 16'hF000.
- R3: For a pin whose `dir` bit is 0, the read bit equals that pin's `pin_in` level as sampled two rising clock edges earlier.
- R4: For a pin whose `dir` bit is 1, the read bit equals the latched bit, whatever `pin_in` or `func_gpio` hold.
- R5: An accepted write (`wr_en`=1, `addr`=REG_ADDR, no standby or retention source active) stores `wdata[11:0]` on the next rising edge, regardless of `dir` or `func_gpio`.
- R6: `pin_oe[n]` is 1 exactly when `dir[n]`=1 and `func_gpio[n]`=1. `pin_out[n]` equals latched bit n when `pin_oe[n]`=1, and 0 otherwise.
- R7: A rising edge with `hw_stby`=1 clears bits 11..0 of the latch, and any write in that cycle is dropped.
- R8: A rising edge with `wdt_por`, `sw_stby` or `sleep` at 1 (and `hw_stby`=0) leaves the latch unchanged, and any write in that cycle is dropped.
- R9: `rdata` is 16'h0000 unless `rd_en`=1 and `addr`=REG_ADDR. A write to any other address leaves the latch unchanged.
- R10: When a read and an accepted write occur in the same cycle, `rdata` shows the latch value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| por_n | input | 1 | Full power-on reset, asynchronous, active low |
| wdt_por | input | 1 | Watchdog-caused power-on reset (retains contents) |
| hw_stby | input | 1 | Hardware standby (clears contents) |
| sw_stby | input | 1 | Software standby (retains contents) |
| sleep | input | 1 | Sleep mode (retains contents) |
| addr | input | 4 | Register bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not selected |
| dir | input | 12 | Per-pin direction, 1 = output |
| func_gpio | input | 12 | Per-pin function select, 1 = plain I/O |
| pin_in | input | 12 | Raw pad levels |
| pin_out | output | 12 | Per-pin drive value |
| pin_oe | output | 12 | Per-pin output enable |

## Verification
The readback mux is tried with all-output and all-input directions and with alternating and nibble-split direction masks. In each case the pad levels are set as the bitwise complement or an unrelated pattern of the written data, so every read bit shows whether it came from the latch or from the pad. The function-select masks are crossed against the direction masks, which separates the output enable from the direction alone and shows that a non-plain-I/O output neither drives nor changes readback. Directed cases cover the following:
- the written-but-not-driven input pin, revealed later by flipping it to output;
- the two-edge synchronizer lag;
- each reset source, which tells clearing sources from retaining ones;
- a same-cycle read and write.

// File: rtl/gpio_data_pkg.sv
package gpio_data_pkg;
   // Decoded bus access for one cycle
   typedef struct packed {
      logic rd;
      logic wr;
   } bus_sel_t;

   // What the latch does on the coming edge
   typedef enum logic [1:0] {
      LATCH_KEEP  = 2'd0,
      LATCH_LOAD  = 2'd1,
      LATCH_CLEAR = 2'd2
   } latch_op_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_data_store.sv
module gpio_data_store
   import gpio_data_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  latch_op_e    op,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         unique case (op)
            LATCH_CLEAR: q <= '0;
            LATCH_LOAD:  q <= wd;
            default:     q <= q;
         endcase
      end
   end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
   parameter int NPINS = 12,
   parameter int REG_W = 16
) (
   input  logic             sel_rd,
   input  logic [NPINS-1:0] dir,
   input  logic [NPINS-1:0] stored,
   input  logic [NPINS-1:0] synced,
   output logic [REG_W-1:0] rdata
);
   logic [REG_W-1:0] word;

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      assign word[n] = dir[n] ? stored[n] : synced[n];
   end

   if (REG_W > NPINS) begin : g_resv
      assign word[REG_W-1:NPINS] = '1;
   end

   assign rdata = sel_rd ? word : '0;
endmodule

// File: rtl/gpio_data_port.sv
module gpio_data_port
   import gpio_data_pkg::*;
#(
   parameter int          NPINS        = 12,
   parameter int          REG_W        = 16,
   parameter int          ADDR_W       = 4,
   parameter int          REG_ADDR     = 0,
   parameter int          SYNC_STAGES  = 2,
   parameter bit          GATE_PIN_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wdt_por,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic [NPINS-1:0]  dir,
   input  logic [NPINS-1:0]  func_gpio,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe
);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

   if (NPINS < 1 || NPINS > REG_W) begin : g_bad_npins
      $error("gpio_data_port: NPINS must be in 1..REG_W");
   end
   if (REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_data_port: REG_ADDR does not fit ADDR_W");
   end

   // Bus decode
   bus_sel_t  acc;
   latch_op_e op;
   logic      retain;

   assign acc.rd = rd_en && (addr == SEL_ADDR);
   assign acc.wr = wr_en && (addr == SEL_ADDR);
   assign retain = wdt_por | sw_stby | sleep;

   always_comb begin
      if (hw_stby)                op = LATCH_CLEAR;
      else if (acc.wr && !retain) op = LATCH_LOAD;
      else                        op = LATCH_KEEP;
   end

   if (REG_W > NPINS) begin : g_unused_hi
      logic unused_resv_bits;
      assign unused_resv_bits = ^wdata[REG_W-1:NPINS];
   end

   // Storage, synchronizer, readback
   logic [NPINS-1:0] stored;
   logic [NPINS-1:0] synced;

   gpio_data_store #(.W(NPINS)) u_store (
      .clk   (clk),
      .rst_n (por_n),
      .op    (op),
      .wd    (wdata[NPINS-1:0]),
      .q     (stored)
   );

   gpio_pin_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (por_n),
      .d     (pin_in),
      .q     (synced)
   );

   gpio_read_mux #(.NPINS(NPINS), .REG_W(REG_W)) u_rmux (
      .sel_rd (acc.rd),
      .dir    (dir),
      .stored (stored),
      .synced (synced),
      .rdata  (rdata)
   );

   // Pad drive
   for (genvar n = 0; n < NPINS; n++) begin : g_pad
      assign pin_oe[n] = dir[n] & func_gpio[n];
      if (GATE_PIN_OUT) begin : g_gated
         assign pin_out[n] = pin_oe[n] & stored[n];
      end else begin : g_raw
         assign pin_out[n] = stored[n];
      end
   end
endmodule

// File: rtl/gpio_data_port_chk.sv
module gpio_data_port_chk #(
   parameter int NPINS    = 12,
   parameter int REG_W    = 16,
   parameter int ADDR_W   = 4,
   parameter int REG_ADDR = 0
) (
   input logic              clk,
   input logic              por_n,
   input logic              wdt_por,
   input logic              hw_stby,
   input logic              sw_stby,
   input logic              sleep,
   input logic [ADDR_W-1:0] addr,
   input logic              rd_en,
   input logic [REG_W-1:0]  rdata,
   input logic [NPINS-1:0]  dir,
   input logic [NPINS-1:0]  pin_in,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   logic rd_hit;
   assign rd_hit = rd_en && (addr == ADDR_W'(REG_ADDR));

   // R1
   resv_ones_chk: assert property (@(posedge clk) disable iff (!por_n)
      rd_hit |-> &rdata[REG_W-1:NPINS]);

   // R9
   unsel_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rd_hit |-> rdata == '0);

   // R6
   oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pin_oe & ~dir) == '0 && (pin_out & ~pin_oe) == '0);

   // R7
   hw_stby_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      hw_stby |=> pin_out == '0);

   // R8
   retain_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_por || sw_stby || sleep) && !hw_stby |=>
         (pin_oe != $past(pin_oe)) || (pin_out == $past(pin_out)));

   // R3
   for (genvar n = 0; n < NPINS; n++) begin : g_lag
      in_lag_chk: assert property (@(posedge clk) disable iff (!por_n)
         (since_rst == 2'd3) && rd_hit && !dir[n] |-> rdata[n] == $past(pin_in[n], 2));
   end
endmodule

bind gpio_data_port gpio_data_port_chk #(
   .NPINS(NPINS), .REG_W(REG_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
   .clk(clk), .por_n(por_n), .wdt_por(wdt_por), .hw_stby(hw_stby),
   .sw_stby(sw_stby), .sleep(sleep), .addr(addr), .rd_en(rd_en),
   .rdata(rdata), .dir(dir), .pin_in(pin_in), .pin_out(pin_out),
   .pin_oe(pin_oe)
);

// File: tb/tb_gpio_data_port.sv
`timescale 1ns/100ps
module tb_gpio_data_port;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        wdt_por = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, sleep = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [11:0] dir = '0, func_gpio = '0, pin_in = '0;
   logic [11:0] pin_out, pin_oe;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_data_port dut (
      .clk(clk), .por_n(por_n), .wdt_por(wdt_por), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .sleep(sleep), .addr(addr), .wr_en(wr_en),
      .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .dir(dir),
      .func_gpio(func_gpio), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_read(input logic [3:0] a, output logic [15:0] v);
      addr = a; rd_en = 1'b1;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   // stimulus: {dir, func_gpio, pin_in, write data}
   localparam logic [47:0] VEC [6] = '{
      {12'hFFF, 12'hFFF, 12'h000, 12'hA5A},
      {12'h000, 12'hFFF, 12'h3C9, 12'h777},
      {12'hF0F, 12'h0FF, 12'h5AF, 12'h123},
      {12'h0F0, 12'hF0F, 12'hFFF, 12'h000},
      {12'hAAA, 12'h555, 12'h555, 12'hAAA},
      {12'h555, 12'hFFF, 12'hAAA, 12'h555}
   };

   initial begin
      #(200000 * 4);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [11:0] d, f, p, w;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      dir = 12'hFFF; func_gpio = 12'hFFF;
      do_read(4'h0, v);
      check("R2 reset readback", v, 16'hF000);
      check("R2 reset pin_out", {4'h0, pin_out}, 16'h0000);

      // table walk: R3 R4 R6
      for (int i = 0; i < 6; i++) begin
         {d, f, p, w} = VEC[i];
         @(negedge clk);
         dir = d; func_gpio = f; pin_in = p;
         do_write(4'h0, {4'h0, w});
         @(negedge clk);
         do_read(4'h0, v);
         check("R3/R4 mixed readback", v, {4'hF, (w & d) | (p & ~d)});
         check("R6 pin_oe", {4'h0, pin_oe}, {4'h0, d & f});
         check("R6 pin_out", {4'h0, pin_out}, {4'h0, w & d & f});
      end

      // R1: reserved bits
      dir = 12'hFFF; func_gpio = 12'hFFF;
      do_write(4'h0, 16'h0FFF);
      do_read(4'h0, v);
      check("R1 reserved ones", v, 16'hFFFF);
      do_write(4'h0, 16'hF000);
      do_read(4'h0, v);
      check("R1 reserved write ignored", v, 16'hF000);
      check("R1 pads untouched", {4'h0, pin_out}, 16'h0000);

      // R5: write while input is stored but not driven
      dir = 12'h000; pin_in = 12'h000;
      do_write(4'h0, 16'h03C3);
      @(negedge clk);
      do_read(4'h0, v);
      check("R5 input read shows pad", v, 16'hF000);
      check("R5 no pad drive", {4'h0, pin_out}, 16'h0000);
      dir = 12'hFFF;
      do_read(4'h0, v);
      check("R5 stored while input", v, 16'hF3C3);

      // R3: two-edge lag
      dir = 12'h000; pin_in = 12'h000;
      repeat (3) @(negedge clk);
      pin_in = 12'hFFF;
      @(negedge clk);
      do_read(4'h0, v);
      check("R3 one edge still old", v, 16'hF000);
      @(negedge clk);
      do_read(4'h0, v);
      check("R3 two edges new", v, 16'hFFFF);

      // R9: unselected read and foreign write
      dir = 12'hFFF;
      do_write(4'h0, 16'h0456);
      do_read(4'h3, v);
      check("R9 wrong address read", v, 16'h0000);
      check("R9 idle rdata", rdata, 16'h0000);
      do_write(4'h5, 16'h0999);
      do_read(4'h0, v);
      check("R9 foreign write ignored", v, 16'hF456);

      // R10: same-cycle read and write
      @(negedge clk);
      addr = 4'h0; wdata = 16'h0BEE; wr_en = 1'b1; rd_en = 1'b1;
      #1 v = rdata;
      check("R10 read before write", v, 16'hF456);
      @(negedge clk);
      wr_en = 1'b0;
      #1 v = rdata;
      check("R10 new value next cycle", v, 16'hFBEE);
      rd_en = 1'b0;

      // R8: retaining sources
      do_write(4'h0, 16'h05A5);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         wdt_por = (k == 0); sw_stby = (k == 1); sleep = (k == 2);
         addr = 4'h0; wdata = 16'h00FF; wr_en = 1'b1;
         @(negedge clk);
         wr_en = 1'b0; wdt_por = 1'b0; sw_stby = 1'b0; sleep = 1'b0;
         do_read(4'h0, v);
         check("R8 contents retained", v, 16'hF5A5);
         check("R8 pads retained", {4'h0, pin_out}, 16'h05A5);
      end

      // R7: hardware standby clears, write dropped
      @(negedge clk);
      hw_stby = 1'b1; addr = 4'h0; wdata = 16'h0777; wr_en = 1'b1;
      @(negedge clk);
      hw_stby = 1'b0; wr_en = 1'b0;
      do_read(4'h0, v);
      check("R7 standby cleared", v, 16'hF000);

      // R2: power-on reset mid-run
      do_write(4'h0, 16'h0123);
      @(negedge clk);
      por_n = 1'b0;
      #1;
      check("R2 pads during reset", {4'h0, pin_out}, 16'h0000);
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      do_read(4'h0, v);
      check("R2 cleared by reset", v, 16'hF000);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule